// File: doc/BRIEF.md
# ECC Read-Modify-Write Sequencer

This block takes byte-strobed write requests and turns them into whole-word accesses on a memory port that stores an ECC code beside every data word and offers no per-byte mask. It checks the strobes of each request and chooses one of three paths:

- **Full write.** Every strobe is set. The word is encoded at once and written with no read.
- **Scrub.** No strobe is set. The block reads the word, corrects it, and writes the corrected value back to the same address. This cleans a single-bit upset out of the array.
- **Partial write.** Some strobes are set. The block reads the old word and corrects it. It then lays the strobed bytes of the new data over the corrected word, computes new check bits, and writes the result.

A read that shows an uncorrectable (double-bit) error stops the sequence. No write takes place, and the write response reports SLVERR.

The request side is a joint address/data handshake. The block raises `aw_ready` and `w_ready` together, and only in a cycle where it is idle and both `aw_valid` and `w_valid` are high. The master must present the address and the data together and hold them until that cycle. From the accepting cycle until the response is taken, both ready signals stay low, so no later request can slip between the read and the write of a sequence.

The memory request port is valid/ready. While `mem_req_ready` is low, the block holds the request and all of its fields unchanged. Read data returns on `mem_rsp_valid`, which carries no ready: the block is always waiting for it after a read is accepted. The response channel is valid/ready. `b_valid` and `b_resp` hold until `b_ready`.

Top module: `ecc_rmw_seq`

## Requirements
- R1: After reset, `b_valid` and `mem_req_valid` are low, and `aw_ready`/`w_ready` are low while no request is offered.
- R2: A request with all strobes set is written to memory with exactly one write and no read, and the stored data equals the request data.
- R3: A request with all strobes clear reads the address once, then writes the corrected word back to that same address. A stored word with one flipped bit (data or check) is restored to its clean codeword.
- R4: A request with some strobes set reads the address before writing. Byte k of the written data is new data byte k when strobe bit k is 1, and otherwise the corrected old byte k. Strobe bit k governs data bits 8k+7..8k.
- R5: The check bits written after a merge are recomputed for the merged data. They equal those produced by a full write of the same data.
- R6: If the read of a scrub or partial write shows a double-bit error, no memory write is issued, the stored word is left as it was, and `b_resp` is SLVERR (2'b10).
- R7: From request acceptance until the response handshake, `aw_ready` and `w_ready` stay low even while a new request is offered.
- R8: `b_valid` rises only after the final memory write has been accepted, or after a double-bit read. `b_resp` is OKAY (2'b00) on success, and `b_valid`/`b_resp` hold until `b_ready`.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted (joint with w_ready) |
| aw_addr | input | ADDR_W | Word address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted (joint with aw_ready) |
| w_data | input | 64 | Write data |
| w_strb | input | 8 | Byte strobes, bit k for data bits 8k+7..8k |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_resp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | 64 | Data to store |
| mem_req_wchk | output | 8 | Check bits to store |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Raw stored data |
| mem_rsp_rchk | input | 8 | Raw stored check bits |

## Verification
The bench goes after the following corner cases:

- **Scrub after corruption.** It flips single data bits and single check bits in stored words and then scrubs. A design that wrote back the raw word, or wrote nothing, would leave the corruption in place.
- **Merge over a bad word.** It runs a partial write onto a word with a single-bit error. A merge that used the uncorrected old bytes would carry the error into the new word.
- **Edge strobe patterns.** It uses patterns with only the lowest or only the highest strobe set. These expose byte-lane misnumbering.
- **Double-bit reads.** It reads words with two flipped bits. A design that ignored the uncorrectable flag would overwrite them and return OKAY.
- **Overlapping request.** It offers a second request while the first is still in progress. A design that let it in would break the atomic read-then-write.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DW       = 64;
  localparam int NB       = DW / 8;
  localparam int HB       = 7;            // Hamming bits for 64 data bits
  localparam int CW       = HB + 1;       // plus overall parity
  localparam int CODE_POS = DW + HB;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {OP_FULL, OP_SCRUB, OP_PART} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR, ST_RESP} st_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          dbe;
  } dec_t;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Data bit j sits at the j-th non-power-of-two codeword position.
  function automatic logic [CW-1:0] ecc_encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int pos = 1; pos <= CODE_POS; pos++) begin
      if (!is_pow2(pos)) begin
        for (int i = 0; i < HB; i++)
          if (pos[i]) c[i] = c[i] ^ d[j];
        j++;
      end
    end
    c[CW-1] = (^d) ^ (^c[HB-1:0]);
    return c;
  endfunction

  function automatic dec_t ecc_decode(logic [DW-1:0] d, logic [CW-1:0] c);
    dec_t r;
    logic [HB-1:0] syn;
    logic ovr;
    int j;
    syn = c[HB-1:0];
    ovr = (^d) ^ (^c);
    j = 0;
    for (int pos = 1; pos <= CODE_POS; pos++) begin
      if (!is_pow2(pos)) begin
        if (d[j]) syn = syn ^ pos[HB-1:0];
        j++;
      end
    end
    r.data = d;
    r.dbe  = 1'b0;
    if (ovr) begin
      j = 0;
      for (int pos = 1; pos <= CODE_POS; pos++) begin
        if (!is_pow2(pos)) begin
          if (pos[HB-1:0] == syn) r.data[j] = ~d[j];
          j++;
        end
      end
    end else if (syn != '0) begin
      r.dbe = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_rmw_strb_class.sv
module ecc_rmw_strb_class
  import ecc_rmw_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES-1:0] strb,
  output op_e               op
);
  always_comb begin
    if (&strb)             op = OP_FULL;
    else if (strb == '0)   op = OP_SCRUB;
    else                   op = OP_PART;
  end
endmodule

// File: rtl/ecc_rmw_merge.sv
module ecc_rmw_merge #(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] new_data,
  input  logic [NBYTES*8-1:0] old_data,
  input  logic [NBYTES-1:0]   strb,
  output logic [NBYTES*8-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = strb[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
  end
endmodule

// File: rtl/ecc_rmw_codec.sv
module ecc_rmw_codec
  import ecc_rmw_pkg::*;
(
  input  logic [DW-1:0] enc_data,
  output logic [CW-1:0] enc_chk,
  input  logic [DW-1:0] dec_data,
  input  logic [CW-1:0] dec_chk,
  output logic [DW-1:0] dec_fixed,
  output logic          dec_dbe
);
  dec_t res;
  always_comb begin
    enc_chk   = ecc_encode(enc_data);
    res       = ecc_decode(dec_data, dec_chk);
    dec_fixed = res.data;
    dec_dbe   = res.dbe;
  end
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DW-1:0]     w_data,
  input  logic [NB-1:0]     w_strb,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        b_resp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  output logic [CW-1:0]     mem_req_wchk,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_rdata,
  input  logic [CW-1:0]     mem_rsp_rchk
);
  st_e               st;
  op_e               op_in, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic [NB-1:0]     strb_q;
  logic [1:0]        resp_q;
  logic [DW-1:0]     rd_fixed, merged;
  logic              rd_dbe;
  logic              accept;

  ecc_rmw_strb_class #(.NBYTES(NB)) u_class (.strb(w_strb), .op(op_in));

  ecc_rmw_codec u_codec (
    .enc_data (data_q),
    .enc_chk  (mem_req_wchk),
    .dec_data (mem_rsp_rdata),
    .dec_chk  (mem_rsp_rchk),
    .dec_fixed(rd_fixed),
    .dec_dbe  (rd_dbe)
  );

  ecc_rmw_merge #(.NBYTES(NB)) u_merge (
    .new_data(data_q),
    .old_data(rd_fixed),
    .strb    (strb_q),
    .merged  (merged)
  );

  assign accept        = (st == ST_IDLE) && aw_valid && w_valid;
  assign aw_ready      = accept;
  assign w_ready       = accept;
  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WR);
  assign mem_req_we    = (st == ST_WR);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = data_q;
  assign b_valid       = (st == ST_RESP);
  assign b_resp        = resp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= OP_FULL;
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
      resp_q <= RESP_OKAY;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          addr_q <= aw_addr;
          data_q <= w_data;
          strb_q <= w_strb;
          op_q   <= op_in;
          resp_q <= RESP_OKAY;
          st     <= (op_in == OP_FULL) ? ST_WR : ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (rd_dbe) begin
            resp_q <= RESP_SLVERR;
            st     <= ST_RESP;
          end else begin
            data_q <= merged;
            st     <= ST_WR;
          end
        end
        ST_WR: if (mem_req_ready) st <= ST_RESP;
        ST_RESP: if (b_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Independent occupancy tracker from port handshakes, for checking R7.
  logic busy_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                         busy_q <= 1'b0;
    else if (aw_valid && aw_ready)      busy_q <= 1'b1;
    else if (b_valid && b_ready)        busy_q <= 1'b0;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !aw_ready && !w_ready); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R9

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_resp)); // R8

  AST_FULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> op_q != OP_FULL); // R2

  AST_OKAY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) && b_resp == RESP_OKAY |->
      $past(mem_req_valid && mem_req_we && mem_req_ready)); // R8

  AST_SLVERR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) && b_resp == RESP_SLVERR |-> $past(mem_rsp_valid)); // R6
endmodule

// File: tb/sim_ecc_rmw_seq.sv
module sim_ecc_rmw_seq;
  import ecc_rmw_pkg::*;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic aw_valid = 0, w_valid = 0, b_ready = 0;
  logic [AW-1:0] aw_addr = '0;
  logic [DW-1:0] w_data = '0;
  logic [NB-1:0] w_strb = '0;
  logic aw_ready, w_ready, b_valid;
  logic [1:0] b_resp;
  logic mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [CW-1:0] mem_req_wchk;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;
  logic [CW-1:0] mem_rsp_rchk;

  ecc_rmw_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_wchk(mem_req_wchk),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_rchk(mem_rsp_rchk)
  );

  // ---------------- memory model ----------------
  logic [CW+DW-1:0] mem [16];
  logic [31:0] cyc;
  int n_rd, n_wr, last_rd_cyc, last_wr_cyc;
  logic [3:0] last_rd_a, last_wr_a;
  logic p1_v;
  logic [3:0] p1_a;
  logic inj_go = 0;
  logic [3:0] inj_a = '0;
  logic [CW+DW-1:0] inj_m = '0;

  assign mem_req_ready = (cyc[1:0] != 2'd2);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      cyc <= '0; n_rd <= 0; n_wr <= 0; last_rd_cyc <= 0; last_wr_cyc <= 0;
      last_rd_a <= '0; last_wr_a <= '0;
      p1_v <= 0; p1_a <= '0; mem_rsp_valid <= 0;
      mem_rsp_rdata <= '0; mem_rsp_rchk <= '0;
    end else begin
      cyc <= cyc + 1;
      p1_v <= 1'b0;
      mem_rsp_valid <= p1_v;
      {mem_rsp_rchk, mem_rsp_rdata} <= mem[p1_a];
      if (inj_go) mem[inj_a] <= mem[inj_a] ^ inj_m;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[3:0]] <= {mem_req_wchk, mem_req_wdata};
          n_wr <= n_wr + 1; last_wr_cyc <= cyc; last_wr_a <= mem_req_addr[3:0];
        end else begin
          p1_v <= 1'b1; p1_a <= mem_req_addr[3:0];
          n_rd <= n_rd + 1; last_rd_cyc <= cyc; last_rd_a <= mem_req_addr[3:0];
        end
      end
    end
  end

  // ---------------- checking infrastructure ----------------
  int checks = 0, fails = 0;
  logic [1:0] exp_q[$];
  int done_cnt = 0, outstanding = 0, hold = 0, r7_viol = 0, r9_viol = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input logic [CW+DW-1:0] act,
                     input logic [CW+DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // Monitor: response scoreboard plus R7 / R9 watch.
  logic prev_stall = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (b_ready) begin
        b_ready = 0; outstanding--; done_cnt++;
      end
      if (outstanding > 0 && (aw_ready || w_ready)) r7_viol++;
      if (prev_stall && !(mem_req_valid && mem_req_we == prev_we && mem_req_addr == prev_addr))
        r9_viol++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_we = mem_req_we; prev_addr = mem_req_addr;
      if (aw_valid && aw_ready) outstanding++;
      if (b_valid && !b_ready) begin
        if (hold == 2) begin
          logic [1:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 2'bxx;
          chk(b_resp === e, "R8 response code", {70'd0, b_resp}, {70'd0, e});
          b_ready = 1; hold = 0;
        end else hold++;
      end
    end
  end

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NB-1:0] s, input logic [1:0] e);
    exp_q.push_back(e);
    @(negedge clk);
    aw_valid = 1; w_valid = 1; aw_addr = a; w_data = d; w_strb = s;
    #1;
    while (!aw_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    aw_valid = 0; w_valid = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int expected_done = 0;
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NB-1:0] s, input logic [1:0] e);
    issue(a, d, s, e);
    expected_done++;
    wait_done(expected_done);
  endtask

  task automatic inject(input logic [3:0] a, input logic [CW+DW-1:0] m);
    @(negedge clk);
    inj_a = a; inj_m = m; inj_go = 1;
    @(negedge clk);
    inj_go = 0;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] ref_merge(logic [DW-1:0] nw, logic [DW-1:0] od,
                                               logic [NB-1:0] s);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = s[b] ? nw[b*8 +: 8] : od[b*8 +: 8];
    return r;
  endfunction

  // Partial write to addr a, then full write of the expected merge to ref address.
  task automatic part_case(input logic [3:0] a, input logic [3:0] refa,
                           input logic [DW-1:0] old_clean, input logic [DW-1:0] nw,
                           input logic [NB-1:0] s, input string tag);
    logic [DW-1:0] e;
    int rd0, wr0;
    e = ref_merge(nw, old_clean, s);
    rd0 = n_rd; wr0 = n_wr;
    do_write({12'd0, a}, nw, s, RESP_OKAY);
    chk(n_rd - rd0 == 1 && n_wr - wr0 == 1 && last_rd_cyc < last_wr_cyc && last_wr_a == a,
        {"R4 read before write ", tag}, {8'd0, 32'(n_rd - rd0), 32'(n_wr - wr0)}, {8'd0, 32'd1, 32'd1});
    chk(mem[a][DW-1:0] == e, {"R4 merged data ", tag}, {8'd0, mem[a][DW-1:0]}, {8'd0, e});
    do_write({12'd0, refa}, e, '1, RESP_OKAY);
    chk(mem[a][CW+DW-1:DW] == mem[refa][CW+DW-1:DW], {"R5 check bits ", tag},
        {64'd0, mem[a][CW+DW-1:DW]}, {64'd0, mem[refa][CW+DW-1:DW]});
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [CW+DW-1:0] cw;
    int rd0, wr0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!b_valid && !mem_req_valid && !aw_ready && !w_ready, "R1 reset outputs",
        {69'd0, b_valid, mem_req_valid, aw_ready}, '0);

    // R2: full write, no read
    rd0 = n_rd; wr0 = n_wr;
    do_write(16'd1, 64'h1122_3344_5566_7788, 8'hFF, RESP_OKAY);
    chk(n_rd == rd0 && n_wr - wr0 == 1, "R2 no read one write",
        {8'd0, 32'(n_rd - rd0), 32'(n_wr - wr0)}, {8'd0, 32'd0, 32'd1});
    chk(mem[1][DW-1:0] == 64'h1122_3344_5566_7788, "R2 stored data",
        {8'd0, mem[1][DW-1:0]}, {8'd0, 64'h1122_3344_5566_7788});

    // R3: scrub repairs data bit and check bit
    do_write(16'd2, 64'hDEAD_BEEF_0123_4567, 8'hFF, RESP_OKAY);
    cw = mem[2];
    inject(4'd2, 72'd1 << 5);
    rd0 = n_rd; wr0 = n_wr;
    do_write(16'd2, 64'h0, 8'h00, RESP_OKAY);
    chk(n_rd - rd0 == 1 && n_wr - wr0 == 1 && last_rd_cyc < last_wr_cyc
        && last_rd_a == 4'd2 && last_wr_a == 4'd2, "R3 scrub read then write",
        {8'd0, 32'(n_rd - rd0), 32'(n_wr - wr0)}, {8'd0, 32'd1, 32'd1});
    chk(mem[2] == cw, "R3 scrub repaired data bit", mem[2], cw);
    inject(4'd2, 72'd1 << (DW + 3));
    do_write(16'd2, 64'h0, 8'h00, RESP_OKAY);
    chk(mem[2] == cw, "R3 scrub repaired check bit", mem[2], cw);

    // R4/R5: partial writes
    part_case(4'd1, 4'd15, 64'h1122_3344_5566_7788, 64'hA0A1_A2A3_A4A5_A6A7, 8'h5A, "5A");
    inject(4'd1, 72'd1 << 40);
    part_case(4'd1, 4'd14, ref_merge(64'hA0A1_A2A3_A4A5_A6A7, 64'h1122_3344_5566_7788, 8'h5A),
              64'h0000_0000_0000_00C3, 8'h01, "lane0 over sbe");
    part_case(4'd2, 4'd13, 64'hDEAD_BEEF_0123_4567, 64'h9900_0000_0000_0000, 8'h80, "lane7");

    // R6: double-bit error blocks write
    do_write(16'd3, 64'h5555_AAAA_5555_AAAA, 8'hFF, RESP_OKAY);
    inject(4'd3, (72'd1 << 0) | (72'd1 << 9));
    cw = mem[3];
    wr0 = n_wr;
    do_write(16'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, RESP_SLVERR);
    chk(n_wr == wr0, "R6 no write on partial dbe", {8'd0, 32'(n_wr - wr0), 32'd0}, '0);
    chk(mem[3] == cw, "R6 word untouched", mem[3], cw);
    do_write(16'd3, 64'h0, 8'h00, RESP_SLVERR);
    chk(n_wr == wr0 && mem[3] == cw, "R6 no write on scrub dbe", mem[3], cw);

    // R2 corner: full write over a damaged word skips the read
    rd0 = n_rd;
    do_write(16'd3, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF, RESP_OKAY);
    chk(n_rd == rd0 && mem[3][DW-1:0] == 64'h0F0F_0F0F_0F0F_0F0F, "R2 overwrite damaged",
        {8'd0, mem[3][DW-1:0]}, {8'd0, 64'h0F0F_0F0F_0F0F_0F0F});

    // R7: second request offered while the first is in progress
    issue(16'd4, 64'h1234_0000_0000_5678, 8'h3C, RESP_OKAY);
    issue(16'd5, 64'hCAFE_F00D_CAFE_F00D, 8'hFF, RESP_OKAY);
    expected_done += 2;
    wait_done(expected_done);
    chk(r7_viol == 0, "R7 ready low while busy", {40'd0, 32'(r7_viol)}, '0);
    chk(mem[5][DW-1:0] == 64'hCAFE_F00D_CAFE_F00D, "R7 queued request completed",
        {8'd0, mem[5][DW-1:0]}, {8'd0, 64'hCAFE_F00D_CAFE_F00D});
    chk(mem[4][DW-1:0] == ref_merge(64'h1234_0000_0000_5678, 64'h0, 8'h3C), "R4 overlapped merge",
        {8'd0, mem[4][DW-1:0]}, {8'd0, ref_merge(64'h1234_0000_0000_5678, 64'h0, 8'h3C)});

    chk(r9_viol == 0, "R9 request held under stall", {40'd0, 32'(r9_viol)}, '0);
    chk(exp_q.size() == 0 && done_cnt == expected_done, "R8 all responses seen",
        {40'd0, 32'(done_cnt)}, {40'd0, 32'(expected_done)});
    report();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    report();
    $finish;
  end
endmodule